// File: doc/BRIEF.md
# Four-Channel Simultaneous-Sample Readout Controller

This block sits on the host side of a four-channel sampling converter. The converter has one shared data location and an active-low completion flag. A one-cycle trigger request makes the controller raise the converter's start strobe for a set number of system clocks. The controller then arms itself on the completion flag. The flag passes through a synchronizer first, and the controller must see it high before it accepts it low, so a flag left low from an earlier conversion cannot start the reads early. Once the flag has gone low, the controller runs four read cycles, each with chip-select and read-enable both low, all against the same location.

The channel of each word comes only from its position in the read sequence. The first word goes to channel 1 and the fourth to channel 4. The controller always collects all four words into shadow storage. It then publishes them together on one wide output, marked by a single-cycle valid pulse.

A timeout covers the case where the flag does not arrive in time. The limit is worked out from the converter's worst-case conversion time, 32.5 us, and the system clock frequency. On a timeout the controller gives an error pulse, issues no reads and returns to idle. A trigger that arrives while a transaction is running is held and serviced once the transaction ends.

Top module: `acq_readout_ctrl`

## Requirements
- R1: While reset is held and straight after it, conv_start_o is low, cs_n_o and rd_n_o are high, samples_vld_o and timeout_err_o are low, and samples_o is all zero.
- R2: A trigger sampled high in idle makes conv_start_o rise on the next clock. The strobe stays high for exactly START_HI_CYC clocks.
- R3: No read is issued until the synchronized completion flag has been seen high and then low after the strobe rose. A flag held low from before the strobe starts no reads. The first read begins SYNC_STAGES+1 clocks after the flag pin goes low.
- R4: Every transaction that completes issues exactly NUM_CH reads. In each read, cs_n_o and rd_n_o are low together for RD_CYC clocks, and the reads are separated by GAP_CYC idle clocks.
- R5: The k-th word read (k = 1..NUM_CH) appears unchanged in samples_o[k*DATA_W-1 : (k-1)*DATA_W], so channel 1 sits in the least significant field. Words are 12-bit two's-complement and are passed through bit for bit.
- R6: samples_vld_o is high for exactly one clock, the clock right after the last read ends. samples_o changes only in that clock.
- R7: If the flag has not been accepted by clock TIMEOUT_CYC-1 after the strobe rose, timeout_err_o pulses for one clock, TIMEOUT_CYC clocks after the strobe rise. That transaction issues no reads and gives no valid pulse, samples_o keeps its previous contents, and the controller returns to idle. TIMEOUT_CYC = ceil(32500 ns x SYS_CLK_MHZ / 1000), which is 4063 at 125 MHz.
- R8: A flag that is accepted in the last allowed clock, TIMEOUT_CYC-1, wins over the timeout: the reads proceed and no error is raised.
- R9: Trigger pulses that arrive while a transaction is busy merge into one pending request. That request starts a new strobe after the current transaction ends, whether it ended with a valid pulse or an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | One-cycle acquisition request |
| conv_done_n_i | input | 1 | Converter completion flag, active low, asynchronous |
| rd_data_i | input | DATA_W | Converter data bus |
| conv_start_o | output | 1 | Start strobe to converter; the rising edge starts a conversion |
| cs_n_o | output | 1 | Converter chip-select, active low |
| rd_n_o | output | 1 | Converter read-enable, active low |
| samples_o | output | NUM_CH*DATA_W | Four packed samples, channel 1 in the low field |
| samples_vld_o | output | 1 | One-cycle pulse when samples_o is updated |
| timeout_err_o | output | 1 | One-cycle pulse when a conversion times out |

## Verification
Flag acceptance and timeout expiry can fall in the same clock. The bench provokes this by dropping the flag pin exactly TIMEOUT_CYC-1-SYNC_STAGES clocks after the strobe rise, so the synchronized flag is accepted in the last allowed clock. It then repeats the run one clock later. In the first run the bench expects the reads to begin at clock TIMEOUT_CYC and no error. In the second run it expects an error pulse at that same clock and no reads. A second overlap also arises: a pending trigger can meet the end of a transaction, and the bench judges it by counting strobe rises after both the valid and the error endings.

// File: rtl/acq_pkg.sv
package acq_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_START,
      S_WAIT,
      S_READ,
      S_GAP
   } acq_state_e;

   // Rounded-up number of system clocks covering the worst-case conversion.
   function automatic int unsigned conv_timeout_cycles(input int unsigned clk_mhz,
                                                       input int unsigned max_ns);
      return (max_ns * clk_mhz + 999) / 1000;
   endfunction

endpackage

// File: rtl/acq_flag_sync.sv
module acq_flag_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] sr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr_q <= '1;
            end else begin
               sr_q[0] <= d_i;
               for (int i = 1; i < STAGES; i++) begin
                  sr_q[i] <= sr_q[i-1];
               end
            end
         end
         assign q_o = sr_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/acq_seq.sv
module acq_seq
   import acq_pkg::*;
#(
   parameter int NUM_CH       = 4,
   parameter int START_HI_CYC = 2,
   parameter int RD_CYC       = 2,
   parameter int GAP_CYC      = 1,
   parameter int TIMEOUT_CYC  = 4063,
   localparam int CH_W  = $clog2(NUM_CH),
   localparam int PH_MX = (START_HI_CYC > RD_CYC) ?
                          ((START_HI_CYC > GAP_CYC) ? START_HI_CYC : GAP_CYC) :
                          ((RD_CYC > GAP_CYC) ? RD_CYC : GAP_CYC),
   localparam int PH_W  = $clog2(PH_MX + 1),
   localparam int TMO_W = $clog2(TIMEOUT_CYC + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            trig_i,
   input  logic            flag_n_i,
   output logic            start_o,
   output logic            cs_n_o,
   output logic            rd_n_o,
   output logic            cap_o,
   output logic [CH_W-1:0] cap_idx_o,
   output logic            commit_o,
   output logic            err_o
);

   acq_state_e      state_q, state_d;
   logic [PH_W-1:0] ph_q, ph_d;
   logic [TMO_W-1:0] tmo_q, tmo_d;
   logic [CH_W-1:0] ch_q, ch_d;
   logic            pend_q, pend_d;
   logic            seen_hi_q, seen_hi_d;
   logic            err_d;
   logic            start_q, cs_n_q, rd_n_q, err_q;

   always_comb begin
      state_d  = state_q;
      ph_d     = ph_q;
      tmo_d    = tmo_q;
      ch_d     = ch_q;
      cap_o    = 1'b0;
      commit_o = 1'b0;
      err_d    = 1'b0;
      unique case (state_q)
         S_IDLE: begin
            if (trig_i || pend_q) begin
               state_d = S_START;
               ph_d    = '0;
               tmo_d   = '0;
            end
         end
         S_START: begin
            tmo_d = tmo_q + TMO_W'(1);
            if (ph_q == PH_W'(START_HI_CYC - 1)) begin
               state_d = S_WAIT;
               ph_d    = '0;
            end else begin
               ph_d = ph_q + PH_W'(1);
            end
         end
         S_WAIT: begin
            tmo_d = tmo_q + TMO_W'(1);
            if (seen_hi_q && !flag_n_i) begin
               state_d = S_READ;
               ph_d    = '0;
               ch_d    = '0;
            end else if (tmo_q == TMO_W'(TIMEOUT_CYC - 1)) begin
               state_d = S_IDLE;
               err_d   = 1'b1;
            end
         end
         S_READ: begin
            if (ph_q == PH_W'(RD_CYC - 1)) begin
               cap_o = 1'b1;
               ph_d  = '0;
               if (ch_q == CH_W'(NUM_CH - 1)) begin
                  state_d  = S_IDLE;
                  commit_o = 1'b1;
               end else begin
                  state_d = S_GAP;
               end
            end else begin
               ph_d = ph_q + PH_W'(1);
            end
         end
         S_GAP: begin
            if (ph_q == PH_W'(GAP_CYC - 1)) begin
               state_d = S_READ;
               ph_d    = '0;
               ch_d    = ch_q + CH_W'(1);
            end else begin
               ph_d = ph_q + PH_W'(1);
            end
         end
         default: state_d = S_IDLE;
      endcase
   end

   assign pend_d    = (state_q == S_IDLE) ? 1'b0 : (pend_q | trig_i);
   assign seen_hi_d = (state_q == S_IDLE) ? 1'b0 : (seen_hi_q | flag_n_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         ph_q      <= '0;
         tmo_q     <= '0;
         ch_q      <= '0;
         pend_q    <= 1'b0;
         seen_hi_q <= 1'b0;
         start_q   <= 1'b0;
         cs_n_q    <= 1'b1;
         rd_n_q    <= 1'b1;
         err_q     <= 1'b0;
      end else begin
         state_q   <= state_d;
         ph_q      <= ph_d;
         tmo_q     <= tmo_d;
         ch_q      <= ch_d;
         pend_q    <= pend_d;
         seen_hi_q <= seen_hi_d;
         start_q   <= (state_d == S_START);
         cs_n_q    <= (state_d != S_READ);
         rd_n_q    <= (state_d != S_READ);
         err_q     <= err_d;
      end
   end

   assign start_o   = start_q;
   assign cs_n_o    = cs_n_q;
   assign rd_n_o    = rd_n_q;
   assign err_o     = err_q;
   assign cap_idx_o = ch_q;

endmodule

// File: rtl/acq_pack.sv
module acq_pack #(
   parameter int DATA_W = 12,
   parameter int NUM_CH = 4,
   localparam int CH_W  = $clog2(NUM_CH),
   localparam int OUT_W = NUM_CH * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic [CH_W-1:0]   cap_idx_i,
   input  logic              commit_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [OUT_W-1:0]  samples_o,
   output logic              vld_o
);

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
         logic [DATA_W-1:0] lane_q;
         if (ch < NUM_CH - 1) begin : g_shadow
            // Early channels wait in shadow storage until the set is complete.
            logic [DATA_W-1:0] shd_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  shd_q  <= '0;
                  lane_q <= '0;
               end else begin
                  if (cap_i && (cap_idx_i == CH_W'(ch))) shd_q <= data_i;
                  if (commit_i) lane_q <= shd_q;
               end
            end
         end else begin : g_direct
            // The final channel is captured in the same clock as the commit.
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) lane_q <= '0;
               else if (commit_i) lane_q <= data_i;
            end
         end
         assign samples_o[ch*DATA_W +: DATA_W] = lane_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_o <= 1'b0;
      else        vld_o <= commit_i;
   end

endmodule

// File: rtl/acq_readout_ctrl.sv
module acq_readout_ctrl
   import acq_pkg::*;
#(
   parameter int DATA_W       = 12,
   parameter int NUM_CH       = 4,
   parameter int START_HI_CYC = 2,
   parameter int RD_CYC       = 2,
   parameter int GAP_CYC      = 1,
   parameter int SYNC_STAGES  = 2,
   parameter int SYS_CLK_MHZ  = 125,
   parameter int MAX_CONV_NS  = 32500,
   localparam int CH_W        = $clog2(NUM_CH),
   localparam int OUT_W       = NUM_CH * DATA_W,
   localparam int TIMEOUT_CYC = int'(conv_timeout_cycles(SYS_CLK_MHZ, MAX_CONV_NS))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_i,
   input  logic              conv_done_n_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              conv_start_o,
   output logic              cs_n_o,
   output logic              rd_n_o,
   output logic [OUT_W-1:0]  samples_o,
   output logic              samples_vld_o,
   output logic              timeout_err_o
);

   initial begin
      assert (NUM_CH >= 2) else $fatal(1, "NUM_CH must be at least 2");
      assert (DATA_W >= 1) else $fatal(1, "DATA_W must be positive");
      assert (START_HI_CYC >= 1 && RD_CYC >= 1 && GAP_CYC >= 1)
         else $fatal(1, "phase lengths must be at least one clock");
      assert (SYNC_STAGES >= 0) else $fatal(1, "SYNC_STAGES must not be negative");
      assert (TIMEOUT_CYC > START_HI_CYC + SYNC_STAGES + 1)
         else $fatal(1, "timeout shorter than strobe plus flag latency");
   end

   logic            flag_n_s;
   logic            cap;
   logic [CH_W-1:0] cap_idx;
   logic            commit;

   acq_flag_sync #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (conv_done_n_i),
      .q_o  (flag_n_s)
   );

   acq_seq #(
      .NUM_CH      (NUM_CH),
      .START_HI_CYC(START_HI_CYC),
      .RD_CYC      (RD_CYC),
      .GAP_CYC     (GAP_CYC),
      .TIMEOUT_CYC (TIMEOUT_CYC)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_i   (trig_i),
      .flag_n_i (flag_n_s),
      .start_o  (conv_start_o),
      .cs_n_o   (cs_n_o),
      .rd_n_o   (rd_n_o),
      .cap_o    (cap),
      .cap_idx_o(cap_idx),
      .commit_o (commit),
      .err_o    (timeout_err_o)
   );

   acq_pack #(
      .DATA_W(DATA_W),
      .NUM_CH(NUM_CH)
   ) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_i    (cap),
      .cap_idx_i(cap_idx),
      .commit_i (commit),
      .data_i   (rd_data_i),
      .samples_o(samples_o),
      .vld_o    (samples_vld_o)
   );

endmodule

// File: rtl/acq_readout_chk.sv
module acq_readout_chk #(
   parameter int DATA_W       = 12,
   parameter int NUM_CH       = 4,
   parameter int START_HI_CYC = 2,
   localparam int OUT_W       = NUM_CH * DATA_W,
   localparam int HI_W        = $clog2(START_HI_CYC + 2),
   localparam int RC_W        = $clog2(NUM_CH + 2)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             conv_start_o,
   input logic             cs_n_o,
   input logic             rd_n_o,
   input logic [OUT_W-1:0] samples_o,
   input logic             samples_vld_o,
   input logic             timeout_err_o
);

   logic [HI_W-1:0] hi_cnt_q;
   logic [RC_W-1:0] rd_cnt_q;
   logic            rd_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt_q  <= '0;
         rd_cnt_q  <= '0;
         rd_prev_q <= 1'b1;
      end else begin
         hi_cnt_q  <= conv_start_o ? hi_cnt_q + HI_W'(1) : '0;
         rd_prev_q <= rd_n_o;
         if (conv_start_o)               rd_cnt_q <= '0;
         else if (!rd_n_o && rd_prev_q)  rd_cnt_q <= rd_cnt_q + RC_W'(1);
      end
   end

   p_strobe_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(conv_start_o) |-> (hi_cnt_q == HI_W'(START_HI_CYC)));

   p_no_read_in_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |-> rd_n_o);

   p_rd_with_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n_o |-> !cs_n_o);

   p_read_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cnt_q <= RC_W'(NUM_CH));

   p_vld_after_reads_r6: assert property (@(posedge clk) disable iff (!rst_n)
      samples_vld_o |-> (rd_cnt_q == RC_W'(NUM_CH)));

   p_vld_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      samples_vld_o |=> !samples_vld_o);

   p_samples_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !samples_vld_o |-> $stable(samples_o));

   p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err_o |=> !timeout_err_o);

   p_err_no_reads_r7: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err_o |-> (rd_cnt_q == '0) && !samples_vld_o);

endmodule

bind acq_readout_ctrl acq_readout_chk #(
   .DATA_W      (DATA_W),
   .NUM_CH      (NUM_CH),
   .START_HI_CYC(START_HI_CYC)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .conv_start_o (conv_start_o),
   .cs_n_o       (cs_n_o),
   .rd_n_o       (rd_n_o),
   .samples_o    (samples_o),
   .samples_vld_o(samples_vld_o),
   .timeout_err_o(timeout_err_o)
);

// File: tb/tb_acq_readout_ctrl.sv
`timescale 1ns/1ps
module tb_acq_readout_ctrl;

   localparam int DW    = 12;
   localparam int NCH   = 4;
   localparam int SHI   = 3;
   localparam int RDC   = 2;
   localparam int GAPC  = 1;
   localparam int SYNC  = 2;
   localparam int TMO   = (32500 * 125 + 999) / 1000;
   localparam int OW    = NCH * DW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig_i = 1'b0;
   logic          done_n = 1'b1;
   logic [DW-1:0] rd_data;
   logic          conv_start_o, cs_n_o, rd_n_o, samples_vld_o, timeout_err_o;
   logic [OW-1:0] samples_o;

   always #4 clk = ~clk;

   acq_readout_ctrl #(
      .DATA_W(DW), .NUM_CH(NCH), .START_HI_CYC(SHI), .RD_CYC(RDC),
      .GAP_CYC(GAPC), .SYNC_STAGES(SYNC), .SYS_CLK_MHZ(125), .MAX_CONV_NS(32500)
   ) dut (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .conv_done_n_i(done_n),
      .rd_data_i(rd_data), .conv_start_o(conv_start_o), .cs_n_o(cs_n_o),
      .rd_n_o(rd_n_o), .samples_o(samples_o), .samples_vld_o(samples_vld_o),
      .timeout_err_o(timeout_err_o)
   );

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Converter model and port monitor, all on the falling edge.
   logic [DW-1:0] words [NCH];
   int  flag_delay = 1 << 30;
   bit  hold_low = 1'b0;
   int  cyc = 0, since_rise = 0, trig_cyc = -10, rise_cyc = -10;
   int  rd_idx = 0, rd_falls = 0, first_rd_at = -1, cur_w = 0, w_bad = 0, cs_bad = 0;
   int  hi_w = 0, strobes = 0, vld_cnt = 0, err_cnt = 0, vld_at = -1, err_at = -1;
   bit  prev_start = 1'b0, prev_rd_n = 1'b1;

   always_comb rd_data = words[(rd_idx < NCH) ? rd_idx : 0];

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         since_rise++;
         if (trig_i) trig_cyc = cyc;
         if (conv_start_o && !prev_start) begin
            since_rise = 0; rise_cyc = cyc; strobes++;
            if (!hold_low) done_n = 1'b1;
            rd_idx = 0; rd_falls = 0; first_rd_at = -1; w_bad = 0; cs_bad = 0; hi_w = 0;
         end
         if (conv_start_o) hi_w++;
         if (since_rise == flag_delay) done_n = 1'b0;
         if (!rd_n_o && prev_rd_n) begin
            rd_falls++; cur_w = 0;
            if (first_rd_at < 0) first_rd_at = since_rise;
         end
         if (!rd_n_o) begin
            cur_w++;
            if (cs_n_o) cs_bad++;
         end
         if (rd_n_o && !prev_rd_n) begin
            rd_idx++;
            if (cur_w != RDC) w_bad++;
         end
         if (samples_vld_o) begin vld_cnt++; vld_at = since_rise; end
         if (timeout_err_o) begin err_cnt++; err_at = since_rise; end
         prev_start = conv_start_o;
         prev_rd_n  = rd_n_o;
      end
   end

   function automatic logic [DW-1:0] wgen(input int p, input int k);
      if (p == 0) begin
         case (k)
            0: return 12'h800;
            1: return 12'h7FF;
            2: return 12'h000;
            default: return 12'hFFF;
         endcase
      end
      return DW'((p * 937 + k * 1499 + 5) % 4096);
   endfunction

   task automatic pulse_trig();
      @(posedge clk); #2 trig_i = 1'b1;
      @(posedge clk); #2 trig_i = 1'b0;
   endtask

   task automatic wait_end(input int v0, input int e0, input int limit);
      int n = 0;
      while (vld_cnt == v0 && err_cnt == e0 && n < limit) begin
         @(negedge clk); #1; n++;
      end
      repeat (3) begin @(negedge clk); #1; end
   endtask

   // One transaction: flag falls dly clocks after the strobe rise.
   task automatic run_one(input int p, input int dly, input bit hold, input bit exp_ok,
                          input string tag);
      int v0, e0;
      logic [OW-1:0] prev, expv;
      for (int k = 0; k < NCH; k++) words[k] = wgen(p, k);
      for (int k = 0; k < NCH; k++) expv[k*DW +: DW] = words[k];
      prev = samples_o;
      flag_delay = dly; hold_low = hold;
      v0 = vld_cnt; e0 = err_cnt;
      pulse_trig();
      wait_end(v0, e0, TMO + 400);
      chk(rise_cyc == trig_cyc + 1, "R2", {tag, " strobe rise after trigger"}, rise_cyc, trig_cyc + 1);
      chk(hi_w == SHI, "R2", {tag, " strobe width"}, hi_w, SHI);
      if (exp_ok) begin
         chk(first_rd_at == dly + SYNC + 1, "R3", {tag, " first read clock"}, first_rd_at, dly + SYNC + 1);
         chk(rd_falls == NCH, "R4", {tag, " read count"}, rd_falls, NCH);
         chk(w_bad == 0 && cs_bad == 0, "R4", {tag, " read width and select"}, w_bad + cs_bad, 0);
         chk(samples_o == expv, "R5", {tag, " packed samples"}, samples_o, expv);
         chk(vld_cnt == v0 + 1, "R6", {tag, " single valid pulse"}, vld_cnt - v0, 1);
         chk(vld_at == first_rd_at + (NCH - 1) * (RDC + GAPC) + RDC, "R6", {tag, " valid clock"},
             vld_at, first_rd_at + (NCH - 1) * (RDC + GAPC) + RDC);
         chk(err_cnt == e0, "R8", {tag, " no timeout"}, err_cnt - e0, 0);
      end else begin
         chk(err_cnt == e0 + 1, "R7", {tag, " one error pulse"}, err_cnt - e0, 1);
         chk(err_at == TMO, "R7", {tag, " error clock"}, err_at, TMO);
         chk(rd_falls == 0, "R7", {tag, " no reads"}, rd_falls, 0);
         chk(vld_cnt == v0, "R7", {tag, " no valid"}, vld_cnt - v0, 0);
         chk(samples_o == prev, "R7", {tag, " samples kept"}, samples_o, prev);
      end
   endtask

   initial begin
      #(200000 * 8);
      if (!finished) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int s0, v0, e0;
      for (int k = 0; k < NCH; k++) words[k] = '0;
      repeat (3) @(negedge clk);
      // R1: reset values, checked during reset and just after release.
      chk(!conv_start_o && cs_n_o && rd_n_o, "R1", "strobe/select/read in reset",
          {conv_start_o, cs_n_o, rd_n_o}, 3'b011);
      chk(!samples_vld_o && !timeout_err_o, "R1", "pulses in reset",
          {samples_vld_o, timeout_err_o}, 0);
      @(posedge clk); #2 rst_n = 1'b1;
      repeat (2) @(negedge clk); #1;
      chk(samples_o == '0, "R1", "samples after reset", samples_o, 0);
      chk(!conv_start_o && rd_n_o && cs_n_o, "R1", "idle outputs after reset",
          {conv_start_o, cs_n_o, rd_n_o}, 3'b011);

      // R2 R3 R4 R5 R6: sweep data patterns against flag latencies.
      for (int p = 0; p < 6; p++) begin
         for (int d = 0; d < 6; d++) begin
            int dl;
            case (d)
               0: dl = 4; 1: dl = 5; 2: dl = 7; 3: dl = 11; 4: dl = 40; default: dl = 300;
            endcase
            run_one(p, dl, 1'b0, 1'b1, "sweep");
         end
      end

      // R7: flag never falls.
      run_one(7, 1 << 30, 1'b0, 1'b0, "timeout");
      run_one(8, 6, 1'b0, 1'b1, "recover");
      // R3: flag stays low from the previous conversion.
      run_one(9, 1 << 30, 1'b1, 1'b0, "stale-low");
      // R8: flag accepted in the last allowed clock, then one clock too late.
      run_one(10, TMO - 1 - SYNC, 1'b0, 1'b1, "edge-ok");
      run_one(11, TMO - SYNC, 1'b0, 1'b0, "edge-late");

      // R9: two triggers while busy merge into one pending transaction.
      s0 = strobes; v0 = vld_cnt;
      flag_delay = 20; hold_low = 1'b0;
      pulse_trig();
      repeat (8) @(negedge clk);
      pulse_trig();
      repeat (2) @(negedge clk);
      pulse_trig();
      for (int n = 0; n < 2000 && vld_cnt < v0 + 2; n++) begin @(negedge clk); #1; end
      repeat (300) @(negedge clk);
      #1;
      chk(strobes == s0 + 2, "R9", "strobes with merged pending trigger", strobes - s0, 2);
      chk(vld_cnt == v0 + 2, "R9", "both transactions valid", vld_cnt - v0, 2);

      // R9: pending trigger served after a timeout ending.
      s0 = strobes; v0 = vld_cnt; e0 = err_cnt;
      flag_delay = 1 << 30;
      pulse_trig();
      repeat (100) @(negedge clk);
      pulse_trig();
      for (int n = 0; n < TMO + 200 && err_cnt == e0; n++) begin @(negedge clk); #1; end
      flag_delay = 10;
      for (int n = 0; n < 400 && vld_cnt == v0; n++) begin @(negedge clk); #1; end
      chk(err_cnt == e0 + 1, "R9", "first ended by timeout", err_cnt - e0, 1);
      chk(strobes == s0 + 2, "R9", "pending served after error", strobes - s0, 2);
      chk(vld_cnt == v0 + 1, "R9", "pending transaction valid", vld_cnt - v0, 1);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule